// File: doc/BRIEF.md
# Local Bus Read-Cycle Master

This block is a synchronous host-side sequencer that performs single-word reads from a 32-bit peripheral on a local bus. Every bus signal changes on the rising edge of the bus clock. An internal client hands over one request, made of an address and active-low byte enables, through a valid/ready handshake. The master then runs one fixed bus sequence:

- an address strobe pulse;
- a latch cycle;
- a cycle strobe, held until the peripheral claims the transfer;
- a one-clock fetch delay;
- a wait for the peripheral's ready;
- a ready-return handshake that lets the peripheral release the bus.

The captured word comes back to the client with a one-cycle done pulse. If the peripheral fails to claim the transfer or fails to signal ready within a parameter-set number of cycles, the master drops the transfer. It then reports an error with a zero data word. There are no bursts, so each request gives exactly one address phase.

Top module: `lbus_rd_master`

## Requirements
- R1: After reset, all bus outputs are high (address strobe, cycle strobe, write/read select, ready-return, address-enable), the done pulse, error flag and returned data are zero, and `req_ready` is high while `lb_srdy_n` is high.
- R2: A request is accepted only when the master is idle and `lb_srdy_n` is high. `req_ready` is low for the whole of a transfer and while `lb_srdy_n` is held low in idle.
- R3: The clock after acceptance, `lb_ads_n` is low for exactly one cycle. During that cycle `lb_addr` and `lb_be_n` carry the request, and `lb_aen_n` and `lb_wr_rd_n` are low. The next cycle is a latch cycle with `lb_ads_n` high and `lb_cyc_n` still high.
- R4: `lb_cyc_n` falls in the cycle after the latch cycle and is never low at the same time as `lb_ads_n`.
- R5: The master holds the cycle strobe until it samples `lb_claim_n` low. A claim sampled on or before the TMO_CYCLES-th edge of that wait continues the transfer.
- R6: After the claim, exactly one delay cycle passes. Then the master captures `lb_data` on the first edge of the ready wait at which `lb_srdy_n` is low. Ready sampled on the TMO_CYCLES-th edge of the wait still counts.
- R7: `lb_rdyret_n` goes low in the cycle after capture and stays low until `lb_srdy_n` is sampled high. On that edge all bus outputs return high and `rsp_done` pulses for exactly one cycle, with `rsp_err` low and the captured word on `rsp_data`.
- R8: `lb_wr_rd_n` stays low while `lb_srdy_n` is low during a transfer. It rises only after `lb_srdy_n` has been sampled high.
- R9: If no claim is sampled within TMO_CYCLES edges, or no ready within TMO_CYCLES edges of the ready wait, the transfer ends on that edge. `rsp_done` pulses with `rsp_err` high and `rsp_data` zero, and all bus outputs return high.
- R10: Each accepted request produces exactly one address-strobe pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Master can take a request |
| req_addr | input | ADDR_W | Read address |
| req_be_n | input | DATA_W/8 | Active-low byte enables |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Transfer ended by timeout |
| rsp_data | output | DATA_W | Captured read word (zero on error) |
| lb_addr | output | ADDR_W | Bus address |
| lb_be_n | output | DATA_W/8 | Bus byte enables, active low |
| lb_aen_n | output | 1 | Address enable, low while a transfer owns the bus |
| lb_ads_n | output | 1 | Address strobe, active low |
| lb_cyc_n | output | 1 | Cycle strobe, active low |
| lb_wr_rd_n | output | 1 | Write/read select, low for read |
| lb_rdyret_n | output | 1 | Ready-return to peripheral, active low |
| lb_claim_n | input | 1 | Peripheral claims the cycle, active low |
| lb_srdy_n | input | 1 | Peripheral data ready, active low |
| lb_data | input | DATA_W | Read data from peripheral |

## Verification
The bench targets the exact timeout edges. A claim or ready arriving on the last allowed edge must complete the transfer, and one cycle later must abort it. An off-by-one counter would flip one of these outcomes and change the length of the cycle strobe. The bench also holds ready low in idle, which a master that ignores the peripheral's release would accept. It watches for the write/read select rising while ready is still low, and for any junk data captured in place of the ready-cycle word. Ready that shows up during the delay cycle checks that capture waits for the ready-wait state.

// File: rtl/lbus_rd_pkg.sv
package lbus_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LATCH,
        ST_CLAIM,
        ST_DELAY,
        ST_WAIT,
        ST_RET
    } lbr_state_e;

    typedef struct packed {
        logic ads_n;
        logic cyc_n;
        logic wr_rd_n;
        logic rdyret_n;
        logic aen_n;
    } lbr_pins_t;

    localparam lbr_pins_t PINS_IDLE = '{ads_n: 1'b1, cyc_n: 1'b1, wr_rd_n: 1'b1,
                                        rdyret_n: 1'b1, aen_n: 1'b1};

    function automatic lbr_pins_t pins_for(input lbr_state_e s);
        lbr_pins_t p;
        p = PINS_IDLE;
        if (s != ST_IDLE) begin
            p.aen_n   = 1'b0;
            p.wr_rd_n = 1'b0;
        end
        if (s == ST_ADDR)
            p.ads_n = 1'b0;
        if (s == ST_CLAIM || s == ST_DELAY || s == ST_WAIT || s == ST_RET)
            p.cyc_n = 1'b0;
        if (s == ST_RET)
            p.rdyret_n = 1'b0;
        return p;
    endfunction

endpackage

// File: rtl/lbus_rd_timer.sv
module lbus_rd_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (run && !expired)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    // R9: the wait counter never runs past the limit
    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(LIMIT));

endmodule

// File: rtl/lbus_rd_seq.sv
module lbus_rd_seq
    import lbus_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_fire,
    input  logic       claim_n,
    input  logic       srdy_n,
    input  logic       expired,
    output lbr_state_e state_q,
    output lbr_state_e state_d,
    output logic       tmr_clr,
    output logic       tmr_run,
    output logic       capture,
    output logic       finish,
    output logic       abort
);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_fire) state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_LATCH;
            ST_LATCH: state_d = ST_CLAIM;
            ST_CLAIM: begin
                if (!claim_n)     state_d = ST_DELAY;
                else if (expired) state_d = ST_IDLE;
            end
            ST_DELAY: state_d = ST_WAIT;
            ST_WAIT: begin
                if (!srdy_n)      state_d = ST_RET;
                else if (expired) state_d = ST_IDLE;
            end
            ST_RET:   if (srdy_n) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign tmr_run = (state_q == ST_CLAIM) || (state_q == ST_WAIT);
    assign tmr_clr = (state_d != state_q);
    assign capture = (state_q == ST_WAIT) && !srdy_n;
    assign finish  = (state_q == ST_RET) && srdy_n;
    assign abort   = ((state_q == ST_CLAIM) && claim_n && expired) ||
                     ((state_q == ST_WAIT) && srdy_n && expired);

    // R5: the delay phase is only reached after a sampled claim
    a_r5_claim_before_delay: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DELAY) |-> !$past(claim_n));

    // R6: the ready wait always follows exactly one delay cycle
    a_r6_delay_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DELAY) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/lbus_rd_pins.sv
module lbus_rd_pins
    import lbus_rd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BE_W-1:0]   be_in,
    input  lbr_state_e        state_d,
    output lbr_pins_t         pins_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BE_W-1:0]   be_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= PINS_IDLE;
            addr_q <= '0;
            be_q   <= '1;
        end else begin
            pins_q <= pins_for(state_d);
            if (load) begin
                addr_q <= addr_in;
                be_q   <= be_in;
            end
        end
    end

    // R3: the address strobe is a single-cycle pulse
    a_r3_ads_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !pins_q.ads_n |=> pins_q.ads_n);

    // R3: address and enables stay put across the strobe's rising edge
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
        !pins_q.ads_n |=> ($stable(addr_q) && $stable(be_q)));

    // R4: the cycle strobe falls two cycles after the address strobe was low
    a_r4_cyc_after_latch: assert property (@(posedge clk) disable iff (rst)
        $fell(pins_q.cyc_n) |-> ($past(pins_q.ads_n) && !$past(pins_q.ads_n, 2)));

endmodule

// File: rtl/lbus_rd_master.sv
module lbus_rd_master
    import lbus_rd_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int TMO_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W/8-1:0] req_be_n,
    output logic                rsp_done,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_data,
    output logic [ADDR_W-1:0]   lb_addr,
    output logic [DATA_W/8-1:0] lb_be_n,
    output logic                lb_aen_n,
    output logic                lb_ads_n,
    output logic                lb_cyc_n,
    output logic                lb_wr_rd_n,
    output logic                lb_rdyret_n,
    input  logic                lb_claim_n,
    input  logic                lb_srdy_n,
    input  logic [DATA_W-1:0]   lb_data
);
    localparam int BE_W = DATA_W / 8;

    lbr_state_e state_q, state_d;
    lbr_pins_t  pins_q;
    logic       req_fire, tmr_clr, tmr_run, expired;
    logic       capture, finish, abort;
    logic       done_q, err_q;
    logic [DATA_W-1:0] data_q;

    assign req_ready = (state_q == ST_IDLE) && lb_srdy_n;
    assign req_fire  = req_valid && req_ready;

    lbus_rd_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .req_fire (req_fire),
        .claim_n  (lb_claim_n),
        .srdy_n   (lb_srdy_n),
        .expired  (expired),
        .state_q  (state_q),
        .state_d  (state_d),
        .tmr_clr  (tmr_clr),
        .tmr_run  (tmr_run),
        .capture  (capture),
        .finish   (finish),
        .abort    (abort)
    );

    lbus_rd_timer #(.LIMIT(TMO_CYCLES)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (expired)
    );

    lbus_rd_pins #(.ADDR_W(ADDR_W), .BE_W(BE_W)) i_pins (
        .clk     (clk),
        .rst     (rst),
        .load    (req_fire),
        .addr_in (req_addr),
        .be_in   (req_be_n),
        .state_d (state_d),
        .pins_q  (pins_q),
        .addr_q  (lb_addr),
        .be_q    (lb_be_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            data_q <= '0;
        end else begin
            done_q <= finish || abort;
            if (finish) err_q <= 1'b0;
            if (capture) data_q <= lb_data;
            if (abort) begin
                err_q  <= 1'b1;
                data_q <= '0;
            end
        end
    end

    assign rsp_done    = done_q;
    assign rsp_err     = err_q;
    assign rsp_data    = data_q;
    assign lb_aen_n    = pins_q.aen_n;
    assign lb_ads_n    = pins_q.ads_n;
    assign lb_cyc_n    = pins_q.cyc_n;
    assign lb_wr_rd_n  = pins_q.wr_rd_n;
    assign lb_rdyret_n = pins_q.rdyret_n;

    // R2: an accepted request starts the address phase on the next cycle
    a_r2_accept_starts: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !lb_ads_n);

    // R7: ready-return only follows a sampled ready
    a_r7_ret_after_ready: assert property (@(posedge clk) disable iff (rst)
        $fell(lb_rdyret_n) |-> !$past(lb_srdy_n));

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R8: read select held while the peripheral still drives ready
    a_r8_wr_held: assert property (@(posedge clk) disable iff (rst)
        (!lb_srdy_n && !lb_rdyret_n) |-> !lb_wr_rd_n);

    // R9: an error completion leaves the bus idle
    a_r9_err_idle: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_err) |-> (lb_cyc_n && lb_wr_rd_n && lb_aen_n && (rsp_data == '0)));

endmodule

// File: tb/test_lbus_rd_master.sv
`timescale 1ns/1ps
module test_lbus_rd_master;
    localparam int TMO   = 16;
    localparam int NVEC  = 10;
    localparam logic [7:0] NEVER = 8'hFF;

    typedef struct packed {
        logic [15:0] addr;
        logic [3:0]  be_n;
        logic [7:0]  c;
        logic [7:0]  r;
        logic [31:0] data;
        logic        err;
        logic [7:0]  cyc;
    } vec_t;

    // cycle-strobe length: ok -> (c+1)+1+max(1,r)+2 ; claim timeout -> TMO ; ready timeout -> (c+1)+1+TMO
    localparam vec_t VECS [NVEC] = '{
        '{16'h0010, 4'h0, 8'd0,  8'd0,  32'hA5A5_0001, 1'b0, 8'd5},
        '{16'h0124, 4'h3, 8'd2,  8'd0,  32'h1234_5678, 1'b0, 8'd7},
        '{16'h0FF8, 4'hC, 8'd0,  8'd3,  32'h0BAD_F00D, 1'b0, 8'd7},
        '{16'h8000, 4'h0, 8'd4,  8'd5,  32'hFFFF_0000, 1'b0, 8'd13},
        '{16'h4444, 4'h5, 8'd15, 8'd0,  32'h0F0F_0F0F, 1'b0, 8'd20},
        '{16'h2222, 4'h0, 8'd16, 8'd0,  32'h7777_7777, 1'b1, 8'd16},
        '{16'h1357, 4'hA, 8'd0,  8'd16, 32'hCAFE_0016, 1'b0, 8'd20},
        '{16'h2468, 4'h0, 8'd0,  8'd17, 32'hCAFE_0017, 1'b1, 8'd18},
        '{16'hFFFC, 4'hF, NEVER, 8'd0,  32'h1111_1111, 1'b1, 8'd16},
        '{16'h0004, 4'h1, 8'd1,  NEVER, 32'h2222_2222, 1'b1, 8'd19}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_be_n = '1;
    logic        rsp_done, rsp_err;
    logic [31:0] rsp_data;
    logic [15:0] lb_addr;
    logic [3:0]  lb_be_n;
    logic        lb_aen_n, lb_ads_n, lb_cyc_n, lb_wr_rd_n, lb_rdyret_n;
    logic        lb_claim_n, lb_srdy_n;
    logic [31:0] lb_data;

    logic        per_claim_n, per_srdy_n, stuck;
    int          ccnt, rcnt, retcnt;
    logic [7:0]  claim_dly = '0, rdy_dly = '0;
    logic [31:0] per_data = '0;
    int          checks = 0, errors = 0, viol_wr = 0, viol_cyc = 0;

    always #5 clk = ~clk;

    assign lb_claim_n = per_claim_n;
    assign lb_srdy_n  = per_srdy_n && !stuck;
    assign lb_data    = !per_srdy_n ? per_data : 32'hDEAD_BEEF;

    lbus_rd_master #(.ADDR_W(16), .DATA_W(32), .TMO_CYCLES(TMO)) i_lbus_rd_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_be_n(req_be_n), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_data(rsp_data), .lb_addr(lb_addr),
        .lb_be_n(lb_be_n), .lb_aen_n(lb_aen_n), .lb_ads_n(lb_ads_n),
        .lb_cyc_n(lb_cyc_n), .lb_wr_rd_n(lb_wr_rd_n), .lb_rdyret_n(lb_rdyret_n),
        .lb_claim_n(lb_claim_n), .lb_srdy_n(lb_srdy_n), .lb_data(lb_data)
    );

    // peripheral model, changes on the falling edge
    always @(negedge clk) begin
        if (rst || lb_cyc_n) begin
            per_claim_n <= 1'b1;
            per_srdy_n  <= 1'b1;
            ccnt <= 0; rcnt <= 0; retcnt <= 0;
        end else begin
            if (per_claim_n && claim_dly != NEVER) begin
                if (ccnt >= int'(claim_dly)) per_claim_n <= 1'b0;
                else ccnt <= ccnt + 1;
            end
            if (!per_claim_n && per_srdy_n && retcnt == 0 && rdy_dly != NEVER) begin
                if (rcnt >= int'(rdy_dly)) per_srdy_n <= 1'b0;
                else rcnt <= rcnt + 1;
            end
            if (!per_srdy_n && !lb_rdyret_n) begin
                if (retcnt == 1) per_srdy_n <= 1'b1;
                retcnt <= retcnt + 1;
            end
        end
    end

    // bus ordering monitor (R4, R8)
    always @(negedge clk) begin
        if (!rst) begin
            if (!lb_srdy_n && lb_wr_rd_n && !stuck) viol_wr <= viol_wr + 1;
            if (!lb_ads_n && !lb_cyc_n) viol_cyc <= viol_cyc + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int cyc_cnt, ads_cnt, n;
        logic [31:0] exp_data;
        claim_dly = v.c; rdy_dly = v.r; per_data = v.data;
        exp_data = v.err ? 32'h0 : v.data;
        @(negedge clk);
        req_addr = v.addr; req_be_n = v.be_n; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!lb_ads_n && !lb_aen_n && !lb_wr_rd_n, "R3", "address phase strobes",
            {lb_ads_n, lb_aen_n, lb_wr_rd_n}, 3'b000);
        chk(lb_addr == v.addr && lb_be_n == v.be_n, "R3", "address/enables",
            {lb_addr, lb_be_n}, {v.addr, v.be_n});
        chk(!req_ready, "R2", "busy during transfer", req_ready, 0);
        @(negedge clk);
        chk(lb_ads_n && lb_cyc_n && lb_addr == v.addr, "R3", "latch cycle",
            {lb_ads_n, lb_cyc_n}, 2'b11);
        cyc_cnt = 0; ads_cnt = 1; n = 0;
        while (!rsp_done && n < 200) begin
            @(negedge clk);
            if (!lb_cyc_n) cyc_cnt++;
            if (!lb_ads_n) ads_cnt++;
            n++;
        end
        chk(rsp_done, "R7", "done seen", rsp_done, 1);
        chk(rsp_err == v.err, v.err ? "R9" : "R7", "error flag", rsp_err, v.err);
        chk(rsp_data == exp_data, v.err ? "R9" : "R6", "read data", rsp_data, exp_data);
        chk(cyc_cnt == int'(v.cyc), v.err ? "R9" : "R5", "cycle strobe length", cyc_cnt, v.cyc);
        chk(ads_cnt == 1, "R10", "one address pulse", ads_cnt, 1);
        chk(lb_ads_n && lb_cyc_n && lb_wr_rd_n && lb_rdyret_n && lb_aen_n, "R7",
            "bus idle at done",
            {lb_ads_n, lb_cyc_n, lb_wr_rd_n, lb_rdyret_n, lb_aen_n}, 5'h1F);
        @(negedge clk);
        chk(!rsp_done, "R7", "done single pulse", rsp_done, 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        stuck = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(lb_ads_n && lb_cyc_n && lb_wr_rd_n && lb_rdyret_n && lb_aen_n, "R1",
            "bus outputs after reset",
            {lb_ads_n, lb_cyc_n, lb_wr_rd_n, lb_rdyret_n, lb_aen_n}, 5'h1F);
        chk(!rsp_done && !rsp_err && rsp_data == 0, "R1", "response after reset",
            {rsp_done, rsp_err, rsp_data}, 0);
        chk(req_ready, "R1", "ready after reset", req_ready, 1);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
            repeat (2) @(negedge clk);
        end

        // R2: peripheral ready held low in idle blocks acceptance
        stuck = 1'b1;
        req_addr = 16'h0ABC; req_valid = 1'b1;
        @(negedge clk);
        chk(!req_ready, "R2", "ready low while srdy low", req_ready, 0);
        @(negedge clk);
        chk(lb_ads_n, "R2", "no address phase while srdy low", lb_ads_n, 1);
        req_valid = 1'b0;
        stuck = 1'b0;
        @(negedge clk);
        chk(req_ready, "R2", "ready back after srdy release", req_ready, 1);

        run_vec(VECS[0]);
        repeat (2) @(negedge clk);

        chk(viol_wr == 0, "R8", "select rose while srdy low", viol_wr, 0);
        chk(viol_cyc == 0, "R4", "cycle strobe overlapped address strobe", viol_cyc, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule